// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block stands between a host memory bus and a static memory array and keeps the stored contents safe while the main supply is lost and restored. It receives digitised supply-comparator flags (supply in tolerance, one below-protect flag for each supply-tolerance grade, and below-switchover). All of them are resynchronised to the block clock. From these flags it derives three outputs: a write-protect level, a backup-source select, and a one-time "backup armed" seal.

While protection is active, the host chip-enable, write-enable and output-enable strobes never reach the array. The read-data drivers are also turned off. Protection starts at reset and starts again whenever the selected protect flag asserts. It is released only after the supply has stayed in tolerance, with no protect condition, for a parameterised number of clock cycles without interruption. The seal keeps the backup source disconnected until the supply first rises above the protect threshold. After that it stays set until the next reset.

Top module: `pfwp_supervisor`

## Requirements
- R1: While reset is held and in the first cycle after it, `wp_o`=1, `armed_o`=0, `bkp_sel_o`=0, all three memory strobes read 1 and `dq_oe_o`=0.
- R2: The protect flag is chosen by `grade_sel_i`: 1 selects `below_prot_tight_i` and 0 selects `below_prot_loose_i`. The other flag has no effect. A selected flag of 1 makes `wp_o` read 1 at the third rising edge after the flag changes.
- R3: While `wp_o`=1, `mem_ce_n_o`, `mem_we_n_o` and `mem_oe_n_o` read 1, `dq_oe_o`=0 and `dq_o`=0, whatever the host strobes and `mem_rdata_i` are.
- R4: While `wp_o`=0, each memory strobe equals its host strobe in the same cycle. `dq_oe_o` = (ce_n=0 and oe_n=0 and we_n=1). `dq_o` equals `mem_rdata_i` when `dq_oe_o`=1 and 0 otherwise.
- R5: Suppose `supply_ok_i`=1 and the selected protect flag is 0, both driven together and held. Then `wp_o` falls exactly at the (RECOVERY_CYCLES+2)-th rising edge after that change, and not earlier.
- R6: A drop of `supply_ok_i` during the hold-off restarts the count. `wp_o` then falls at the (RECOVERY_CYCLES+2)-th rising edge after `supply_ok_i` returns to 1.
- R7: `armed_o` becomes 1 at the third rising edge after the selected protect flag first reads 0. It stays 1 through later supply failures until reset.
- R8: `bkp_sel_o` becomes `armed_o` AND the below-switchover flag at the third rising edge after that flag changes. It never reads 1 while `armed_o`=0.
- R9: A write in progress when protection asserts is cut short. `mem_we_n_o` rises in the same cycle as `wp_o`, and it never reads 0 while `wp_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grade_sel_i | input | 1 | 1 = tight tolerance grade, 0 = loose grade |
| supply_ok_i | input | 1 | Comparator: supply within tolerance |
| below_prot_tight_i | input | 1 | Comparator: below tight-grade protect threshold |
| below_prot_loose_i | input | 1 | Comparator: below loose-grade protect threshold |
| below_swo_i | input | 1 | Comparator: below backup switchover level |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| host_we_n_i | input | 1 | Host write enable, active low |
| host_oe_n_i | input | 1 | Host output enable, active low |
| mem_rdata_i | input | DATA_W | Read data from the array |
| mem_ce_n_o | output | 1 | Gated chip enable to the array |
| mem_we_n_o | output | 1 | Gated write enable to the array |
| mem_oe_n_o | output | 1 | Gated output enable to the array |
| dq_o | output | DATA_W | Read data toward the host bus |
| dq_oe_o | output | 1 | Host data driver enable; 0 = high impedance |
| wp_o | output | 1 | Write protection active |
| bkp_sel_o | output | 1 | Array retention supply taken from the backup source |
| armed_o | output | 1 | Backup source seal released |

## Verification
Several rules are checked by the assertions on every cycle. No strobe or data driver gets through while protection is on. The backup select is never set while unarmed, and it moves only toward the synchronised switchover flag. The seal never clears. Protection is released only after a cycle in which the supply was in tolerance and no protect flag was set. A protect condition always raises protection one edge later. Some behaviour can only be shown by the bench's scenarios, which count edges from each input change: the exact release edge after the full hold-off, the restart after a mid-count supply dip, the grade selection that makes the other flag irrelevant, and the pass-through truth table over every host strobe pattern.

// File: rtl/pfwp_pkg.sv
// Package: shared flag bundle and its fail-safe reset value for the
// power-fail supervisor. Assumes all flags are active-high levels.
package pfwp_pkg;

    typedef struct packed {
        logic ok;          // supply within tolerance
        logic fail_tight;  // below tight-grade protect threshold
        logic fail_loose;  // below loose-grade protect threshold
        logic swo;         // below backup switchover level
    } supply_flags_t;

    localparam int FLAG_W = $bits(supply_flags_t);

    // Reset value assumes the worst: supply bad, below every threshold.
    localparam supply_flags_t FLAGS_SAFE = '{ok: 1'b0, fail_tight: 1'b1,
                                             fail_loose: 1'b1, swo: 1'b1};

endpackage

// File: rtl/pfwp_sync.sv
// Two-flop synchroniser, one independent chain per bit.
// Assumes each input bit is a slow level; no multi-bit coherence is implied.
module pfwp_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d_i[b];
                stab_q <= meta_q;
            end
        end

        assign q_o[b] = stab_q;
    end

endmodule

// File: rtl/pfwp_recovery.sv
// Protection state and hold-off counter. A protect condition raises
// protection at once. Release needs RECOVERY_CYCLES consecutive cycles
// of "supply ok and no protect condition". Assumes synchronised inputs.
module pfwp_recovery #(
    parameter int RECOVERY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic ok_i,
    output logic wp_o
);

    localparam int                CNT_W = $clog2(RECOVERY_CYCLES + 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(RECOVERY_CYCLES - 1);

    logic             wp_q;
    logic [CNT_W-1:0] cnt_q;

    // Raise protection on failure; count an unbroken good interval to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= 1'b1;
            cnt_q <= '0;
        end else if (fail_i) begin
            wp_q  <= 1'b1;
            cnt_q <= '0;
        end else if (!ok_i) begin
            cnt_q <= '0;
        end else if (wp_q) begin
            if (cnt_q == LAST) begin
                wp_q  <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign wp_o = wp_q;

endmodule

// File: rtl/pfwp_seal.sv
// One-time backup seal and backup-source select. The seal sets on the
// first cycle with no protect condition and holds until reset. The select
// follows the switchover flag only while sealed-off is released.
module pfwp_seal (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic swo_i,
    output logic armed_o,
    output logic bkp_sel_o
);

    logic armed_q;
    logic bkp_q;

    // Sticky arming on the first healthy supply.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_q | ~fail_i;
    end

    // Backup select follows the switchover flag once armed.
    always_ff @(posedge clk) begin
        if (!rst_n) bkp_q <= 1'b0;
        else        bkp_q <= armed_q & swo_i;
    end

    assign armed_o   = armed_q;
    assign bkp_sel_o = bkp_q;

endmodule

// File: rtl/pfwp_gate.sv
// Combinational bus gate. Blocks strobes and read drivers while protection
// is on; passes them through otherwise. Assumes active-low host strobes.
module pfwp_gate #(
    parameter int DATA_W = 8
) (
    input  logic              wp_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              ce_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);

    logic rd_en;

    // Strobe blocking and read-driver enable.
    always_comb begin
        ce_n_o  = ce_n_i | wp_i;
        we_n_o  = we_n_i | wp_i;
        oe_n_o  = oe_n_i | wp_i;
        rd_en   = ~wp_i & ~ce_n_i & ~oe_n_i & we_n_i;
        dq_oe_o = rd_en;
        dq_o    = rd_en ? rdata_i : '0;
    end

endmodule

// File: rtl/pfwp_supervisor.sv
// Top: power-fail write-protect supervisor. Synchronises comparator flags,
// picks the protect flag for the configured grade, and drives protection,
// seal and backup select. grade_sel_i is assumed static during operation.
module pfwp_supervisor #(
    parameter int DATA_W          = 8,
    parameter int RECOVERY_CYCLES = 6250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grade_sel_i,
    input  logic              supply_ok_i,
    input  logic              below_prot_tight_i,
    input  logic              below_prot_loose_i,
    input  logic              below_swo_i,
    input  logic              host_ce_n_i,
    input  logic              host_we_n_i,
    input  logic              host_oe_n_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_ce_n_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              wp_o,
    output logic              bkp_sel_o,
    output logic              armed_o
);
    import pfwp_pkg::*;

    supply_flags_t raw_flags;
    supply_flags_t syn_flags;
    logic          sel_fail;
    logic          wp;

    // Bundle raw comparator flags.
    always_comb begin
        raw_flags.ok         = supply_ok_i;
        raw_flags.fail_tight = below_prot_tight_i;
        raw_flags.fail_loose = below_prot_loose_i;
        raw_flags.swo        = below_swo_i;
    end

    pfwp_sync #(.W(FLAG_W), .RST_VAL(FLAGS_SAFE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_flags),
        .q_o   (syn_flags)
    );

    // Grade selection of the protect threshold flag.
    always_comb begin
        sel_fail = grade_sel_i ? syn_flags.fail_tight : syn_flags.fail_loose;
    end

    pfwp_recovery #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_recovery (
        .clk    (clk),
        .rst_n  (rst_n),
        .fail_i (sel_fail),
        .ok_i   (syn_flags.ok),
        .wp_o   (wp)
    );

    pfwp_seal u_seal (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_i    (sel_fail),
        .swo_i     (syn_flags.swo),
        .armed_o   (armed_o),
        .bkp_sel_o (bkp_sel_o)
    );

    pfwp_gate #(.DATA_W(DATA_W)) u_gate (
        .wp_i    (wp),
        .ce_n_i  (host_ce_n_i),
        .we_n_i  (host_we_n_i),
        .oe_n_i  (host_oe_n_i),
        .rdata_i (mem_rdata_i),
        .ce_n_o  (mem_ce_n_o),
        .we_n_o  (mem_we_n_o),
        .oe_n_o  (mem_oe_n_o),
        .dq_o    (dq_o),
        .dq_oe_o (dq_oe_o)
    );

    assign wp_o = wp;

endmodule

// File: rtl/pfwp_checker.sv
// Checker for pfwp_supervisor: temporal rules on protection, seal and
// backup select. Attached by the bind statement at the end of this file.
module pfwp_checker (
    input logic clk,
    input logic rst_n,
    input logic s_ok,
    input logic s_fail,
    input logic s_swo,
    input logic wp_o,
    input logic armed_o,
    input logic bkp_sel_o,
    input logic mem_ce_n_o,
    input logic mem_we_n_o,
    input logic mem_oe_n_o,
    input logic dq_oe_o
);

    // R3
    strobe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_o |-> (mem_ce_n_o && mem_oe_n_o && !dq_oe_o));

    // R9
    write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_o |-> mem_we_n_o);

    // R2
    fail_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_fail |=> wp_o);

    // R5
    release_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wp_o) |-> ($past(s_ok) && !$past(s_fail)));

    // R7
    seal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> armed_o);

    // R8
    bkp_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkp_sel_o |-> armed_o);

    // R8
    bkp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bkp_sel_o) |-> $past(s_swo));

    // R8
    bkp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bkp_sel_o) |-> !$past(s_swo));

endmodule

bind pfwp_supervisor pfwp_checker u_pfwp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_ok       (syn_flags.ok),
    .s_fail     (sel_fail),
    .s_swo      (syn_flags.swo),
    .wp_o       (wp_o),
    .armed_o    (armed_o),
    .bkp_sel_o  (bkp_sel_o),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_we_n_o (mem_we_n_o),
    .mem_oe_n_o (mem_oe_n_o),
    .dq_oe_o    (dq_oe_o)
);

// File: tb/pfwp_supervisor_bench.sv
module pfwp_supervisor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int RC         = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          grade, ok, ftight, floose, swo;
    logic          ce_n, we_n, oe_n;
    logic [DW-1:0] rdata;
    logic          m_ce_n, m_we_n, m_oe_n, dq_oe, wp, bkp, armed;
    logic [DW-1:0] dq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfwp_supervisor #(.DATA_W(DW), .RECOVERY_CYCLES(RC)) u_pfwp_supervisor (
        .clk(clk), .rst_n(rst_n), .grade_sel_i(grade), .supply_ok_i(ok),
        .below_prot_tight_i(ftight), .below_prot_loose_i(floose),
        .below_swo_i(swo), .host_ce_n_i(ce_n), .host_we_n_i(we_n),
        .host_oe_n_i(oe_n), .mem_rdata_i(rdata), .mem_ce_n_o(m_ce_n),
        .mem_we_n_o(m_we_n), .mem_oe_n_o(m_oe_n), .dq_o(dq), .dq_oe_o(dq_oe),
        .wp_o(wp), .bkp_sel_o(bkp), .armed_o(armed)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One posedge, then settle to the following negedge for sampling.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Sweep every host strobe pattern with several data values.
    task automatic sweep(input string req, input logic prot);
        for (int i = 0; i < 8; i++) begin
            for (int d = 0; d < 4; d++) begin
                logic c, w, o, en;
                logic [DW-1:0] rd;
                c = i[2]; w = i[1]; o = i[0];
                rd = DW'(d * 83 + 17);
                ce_n = c; we_n = w; oe_n = o; rdata = rd;
                #1;
                en = !prot && !c && !o && w;
                chk(req, {m_ce_n, m_we_n, m_oe_n, dq_oe, dq},
                    {c | prot, w | prot, o | prot, en, en ? rd : {DW{1'b0}}});
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; grade = 1; ok = 0; ftight = 1; floose = 1; swo = 1;
        ce_n = 1; we_n = 1; oe_n = 1; rdata = '0;
        repeat (3) step();
        // R1: state during reset
        chk("R1 reset", {wp, armed, bkp, m_ce_n, m_we_n, m_oe_n, dq_oe}, 7'b1001110);
        rst_n = 1;
        step();
        chk("R1 after reset", {wp, armed, bkp, dq_oe}, 4'b1000);

        // R3: every host pattern blocked while protected
        @(negedge clk);
        sweep("R3 protected gating", 1'b1);
        ce_n = 1; we_n = 1; oe_n = 1;

        // R5/R7: power-up on tight grade; loose flag left high is ignored (R2)
        @(negedge clk);
        ok = 1; ftight = 0; floose = 1; swo = 0;
        for (int e = 1; e <= RC + 2; e++) begin
            step();
            chk("R5 release edge", wp, (e >= RC + 2) ? 0 : 1);
            if (e == 2 || e == 3) chk("R7 arm latency", armed, (e >= 3) ? 1 : 0);
        end

        // R4: pass-through while unprotected
        sweep("R4 pass-through", 1'b0);

        // R9/R2: write in progress, tight flag asserts
        ce_n = 0; we_n = 0; oe_n = 1;
        #1;
        chk("R9 write active before fail", m_we_n, 0);
        @(negedge clk);
        ftight = 1; floose = 0;
        for (int e = 1; e <= 3; e++) begin
            step();
            chk("R2 tight raise", wp, (e >= 3) ? 1 : 0);
            chk("R9 write aborted with wp", m_we_n, (e >= 3) ? 1 : 0);
        end
        chk("R7 sticky over fail", armed, 1);
        ce_n = 1; we_n = 1;

        // R6: supply dip during hold-off restarts the count
        @(negedge clk);
        ftight = 0; ok = 1;
        repeat (6) step();
        ok = 0;
        step();
        ok = 1;
        for (int e = 1; e <= RC + 2; e++) begin
            step();
            chk("R6 restart", wp, (e >= RC + 2) ? 0 : 1);
        end

        // R2: loose grade, tight flag ignored
        floose = 0;
        repeat (3) step();
        grade = 0; ftight = 1;
        repeat (5) step();
        chk("R2 other flag ignored", wp, 0);
        floose = 1;
        for (int e = 1; e <= 3; e++) begin
            step();
            chk("R2 loose raise", wp, (e >= 3) ? 1 : 0);
        end

        // R8: switchover follows flag when armed
        swo = 1;
        for (int e = 1; e <= 3; e++) begin
            step();
            chk("R8 backup on", bkp, (e >= 3) ? 1 : 0);
        end
        swo = 0;
        for (int e = 1; e <= 3; e++) begin
            step();
            chk("R8 backup off", bkp, (e >= 3) ? 0 : 1);
        end

        // R8/R7: after a new reset the seal is closed; switchover has no effect
        rst_n = 0; swo = 1; floose = 1;
        step();
        rst_n = 1;
        repeat (6) step();
        chk("R8 unarmed no backup", {armed, bkp}, 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule